// File: doc/BRIEF.md
# MMD Indirect Access Slave

This block sits behind a parallel clause-22 management port and gives a host indirect access to a small bank of extended registers belonging to one vendor device number. Two clause-22 registers do all the work. The control register holds a two-bit function code and a five-bit device number. The data register means different things depending on that function code. In address mode it holds a latched 16-bit extended address. In data mode it is a window onto the extended register at that address.

To use the block, a host writes the device number to the control register and then writes the target extended address to the data register. Next it rewrites the control register with the data, no-increment function and the same device number. After that, reads and writes of the data register reach the chosen extended register, for example the core PLL settings or the clock-gate enables. Read results are registered and appear the cycle after the read strobe.

Top module: `mmd_indirect_slave`

## Requirements
- R1: The block responds only when the PHY address is 0 and the register number is 13 (control) or 14 (data). Any other PHY address or register number reads as 0x0000, and writes to it change no state.
- R2: A write to register 13 stores bits 15:14 as the function code and bits 4:0 as the device number. A read of register 13 returns those bits, with bits 13:5 reading as zero.
- R3: While the function code is 00 (address), a write to register 14 loads the 16-bit extended address, and a read of register 14 returns that address.
- R4: While the function code is 01 (data, no increment) and the device number is 31, a write to register 14 updates the extended register at the latched address, and a read returns its contents. The address does not change.
- R5: While the function code is 01 and the device number is anything other than 31, register 14 reads as zero and writes to it are ignored.
- R6: The extended bank holds 16 registers at addresses 0 to 15. A data-mode access to an address of 16 or above reads as zero and changes no register.
- R7: With function code 10 or 11, register 14 reads as zero and writes to it are ignored.
- R8: rdData is loaded at the rising edge on which rdStb is high. It keeps its value on every edge without rdStb.
- R9: When rdStb and wrStb are high in the same cycle on the same register, the read returns the value from before the write, and the write still takes effect.
- R10: A synchronous active-high reset clears the function code, the device number, the latched address, every extended register and rdData.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phyAddr | input | 5 | PHY address of the management frame |
| regAddr | input | 5 | Clause-22 register number of the frame |
| wrData | input | 16 | Write data |
| wrStb | input | 1 | One-cycle write strobe |
| rdStb | input | 1 | One-cycle read strobe |
| rdData | output | 16 | Registered read data, valid after the edge that sampled rdStb |

## Verification
A read and a write can land in the same cycle on the same register. The case that matters most is the data register in data mode, where the read must see the extended register's old contents while the write commits the new value. The bench raises both strobes in one cycle on a loaded extended register. It checks that the returned word is the old value, then checks with a plain follow-up read that the new value was stored. The same collision on the control register is judged the same way: the function code that applies is the one from before the write.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int REG_W = 16;
  localparam int DEV_W = 5;
  localparam int FN_W  = 2;

  localparam logic [FN_W-1:0] FN_ADDR = 2'b00;
  localparam logic [FN_W-1:0] FN_DATA = 2'b01;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_CTRL,
    SRC_ADDR,
    SRC_REG
  } rdSrcE;

  typedef struct packed {
    logic  ldCtrl;
    logic  ldAddr;
    logic  ldReg;
    logic  rdEn;
    rdSrcE rdSrc;
  } ctrlStrbT;
endpackage

// File: rtl/mmd_ctrl.sv
module mmd_ctrl
  import mmd_pkg::*;
#(
  parameter int PhyAddr = 0,
  parameter int CtrlReg = 13,
  parameter int DataReg = 14,
  parameter int VendDev = 31
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [4:0]             phyAddr,
  input  logic [4:0]             regAddr,
  input  logic [REG_W-1:0]       wrData,
  input  logic                   wrStb,
  input  logic                   rdStb,
  output ctrlStrbT               strb,
  output logic [REG_W-1:0]       ctrlWord
);
  localparam int PadW = REG_W - FN_W - DEV_W;

  logic [FN_W-1:0]  fnQ;
  logic [DEV_W-1:0] devQ;
  logic phyHit, ctrlHit, dataHit, addrMode, dataMode;

  assign phyHit   = (phyAddr == 5'(PhyAddr));
  assign ctrlHit  = phyHit && (regAddr == 5'(CtrlReg));
  assign dataHit  = phyHit && (regAddr == 5'(DataReg));
  assign addrMode = (fnQ == FN_ADDR);
  assign dataMode = (fnQ == FN_DATA) && (devQ == DEV_W'(VendDev));

  always_ff @(posedge clk) begin
    if (rst) begin
      fnQ  <= '0;
      devQ <= '0;
    end else if (wrStb && ctrlHit) begin
      fnQ  <= wrData[REG_W-1 -: FN_W];
      devQ <= wrData[DEV_W-1:0];
    end
  end

  always_comb begin
    strb.ldCtrl = wrStb && ctrlHit;
    strb.ldAddr = wrStb && dataHit && addrMode;
    strb.ldReg  = wrStb && dataHit && dataMode;
    strb.rdEn   = rdStb;
    if (ctrlHit)                  strb.rdSrc = SRC_CTRL;
    else if (dataHit && addrMode) strb.rdSrc = SRC_ADDR;
    else if (dataHit && dataMode) strb.rdSrc = SRC_REG;
    else                          strb.rdSrc = SRC_ZERO;
  end

  assign ctrlWord = {fnQ, {PadW{1'b0}}, devQ};
endmodule

// File: rtl/mmd_datapath.sv
module mmd_datapath
  import mmd_pkg::*;
#(
  parameter int NumRegs = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] wrData,
  input  ctrlStrbT         strb,
  input  logic [REG_W-1:0] ctrlWord,
  output logic [REG_W-1:0] rdData
);
  localparam int IdxW = (NumRegs > 1) ? $clog2(NumRegs) : 1;

  logic [REG_W-1:0] addrQ;
  logic [REG_W-1:0] regFile [NumRegs];
  logic [IdxW-1:0]  idx;
  logic             inRange;
  logic [REG_W-1:0] regVal;
  logic [REG_W-1:0] selVal;

  assign idx     = addrQ[IdxW-1:0];
  assign inRange = (addrQ < REG_W'(NumRegs));
  assign regVal  = inRange ? regFile[idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) addrQ <= '0;
    else if (strb.ldAddr) addrQ <= wrData;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NumRegs; i++) begin
      if (rst) regFile[i] <= '0;
      else if (strb.ldReg && inRange && (idx == IdxW'(i))) regFile[i] <= wrData;
    end
  end

  always_comb begin
    unique case (strb.rdSrc)
      SRC_CTRL: selVal = ctrlWord;
      SRC_ADDR: selVal = addrQ;
      SRC_REG:  selVal = regVal;
      default:  selVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (strb.rdEn) rdData <= selVal;
  end
endmodule

// File: rtl/mmd_indirect_slave.sv
module mmd_indirect_slave
  import mmd_pkg::*;
#(
  parameter int PhyAddr = 0,
  parameter int VendDev = 31,
  parameter int NumRegs = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  input  logic        wrStb,
  input  logic        rdStb,
  output logic [15:0] rdData
);
  ctrlStrbT         strb;
  logic [REG_W-1:0] ctrlWord;

  mmd_ctrl #(
    .PhyAddr(PhyAddr),
    .CtrlReg(13),
    .DataReg(14),
    .VendDev(VendDev)
  ) uCtrl (
    .clk(clk), .rst(rst), .phyAddr(phyAddr), .regAddr(regAddr),
    .wrData(wrData), .wrStb(wrStb), .rdStb(rdStb),
    .strb(strb), .ctrlWord(ctrlWord)
  );

  mmd_datapath #(.NumRegs(NumRegs)) uDp (
    .clk(clk), .rst(rst), .wrData(wrData), .strb(strb),
    .ctrlWord(ctrlWord), .rdData(rdData)
  );
endmodule

// File: rtl/mmd_indirect_slave_chk.sv
module mmd_indirect_slave_chk #(
  parameter int PhyAddr = 0
) (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  phyAddr,
  input logic [4:0]  regAddr,
  input logic        rdStb,
  input logic [15:0] rdData
);
  AST_RST_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> rdData == 16'h0000);  // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rdStb) && !$past(rst)) |-> $stable(rdData));  // R8

  AST_FOREIGN_PHY: assert property (@(posedge clk) disable iff (rst)
    (rdStb && phyAddr != 5'(PhyAddr)) |=> rdData == 16'h0000);  // R1

  AST_OTHER_REG: assert property (@(posedge clk) disable iff (rst)
    (rdStb && phyAddr == 5'(PhyAddr) && regAddr != 5'd13 && regAddr != 5'd14)
    |=> rdData == 16'h0000);  // R1

  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (rst)
    (rdStb && phyAddr == 5'(PhyAddr) && regAddr == 5'd13)
    |=> rdData[13:5] == 9'h000);  // R2
endmodule

bind mmd_indirect_slave mmd_indirect_slave_chk #(.PhyAddr(PhyAddr)) uChk (
  .clk(clk), .rst(rst), .phyAddr(phyAddr), .regAddr(regAddr),
  .rdStb(rdStb), .rdData(rdData)
);

// File: tb/tb_mmd_indirect_slave.sv
module tb_mmd_indirect_slave;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  phyAddr = '0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic        wrStb = 1'b0;
  logic        rdStb = 1'b0;
  logic [15:0] rdData;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mmd_indirect_slave dut (
    .clk(clk), .rst(rst), .phyAddr(phyAddr), .regAddr(regAddr),
    .wrData(wrData), .wrStb(wrStb), .rdStb(rdStb), .rdData(rdData)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdioWr(logic [4:0] p, logic [4:0] r, logic [15:0] d);
    @(negedge clk);
    phyAddr = p; regAddr = r; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic mdioRd(logic [4:0] p, logic [4:0] r, output logic [15:0] d);
    @(negedge clk);
    phyAddr = p; regAddr = r; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    d = rdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tReset();
    logic [15:0] v;
    mdioRd(0, 13, v); chk("R10 ctrl after reset", v, 16'h0000);
    mdioRd(0, 14, v); chk("R10 addr after reset", v, 16'h0000);
  endtask

  task automatic tCtrl();
    logic [15:0] v;
    mdioWr(0, 13, 16'hFFFF);
    mdioRd(0, 13, v); chk("R2 ctrl readback", v, 16'hC01F);
  endtask

  task automatic tAddrData();
    logic [15:0] v;
    mdioWr(0, 13, 16'h001F);
    mdioWr(0, 14, 16'h0005);
    mdioRd(0, 14, v); chk("R3 address latch", v, 16'h0005);
    mdioWr(0, 13, 16'h401F);
    mdioWr(0, 14, 16'hBEEF);
    mdioRd(0, 14, v); chk("R4 ext reg 5", v, 16'hBEEF);
    mdioWr(0, 13, 16'h001F);
    mdioRd(0, 14, v); chk("R4 address unchanged", v, 16'h0005);
    mdioWr(0, 14, 16'h0003);
    mdioWr(0, 13, 16'h401F);
    mdioWr(0, 14, 16'h1234);
    mdioRd(0, 14, v); chk("R4 ext reg 3", v, 16'h1234);
    mdioWr(0, 13, 16'h001F);
    mdioWr(0, 14, 16'h0005);
    mdioWr(0, 13, 16'h401F);
    mdioRd(0, 14, v); chk("R4 ext reg 5 kept", v, 16'hBEEF);
  endtask

  task automatic tOtherDev();
    logic [15:0] v;
    mdioWr(0, 13, 16'h4007);
    mdioRd(0, 14, v); chk("R5 other device read", v, 16'h0000);
    mdioWr(0, 14, 16'hAAAA);
    mdioWr(0, 13, 16'h401F);
    mdioRd(0, 14, v); chk("R5 other device write ignored", v, 16'hBEEF);
  endtask

  task automatic tRange();
    logic [15:0] v;
    mdioWr(0, 13, 16'h001F);
    mdioWr(0, 14, 16'h0010);
    mdioWr(0, 13, 16'h401F);
    mdioWr(0, 14, 16'h5555);
    mdioRd(0, 14, v); chk("R6 out of range read", v, 16'h0000);
    mdioWr(0, 13, 16'h001F);
    mdioWr(0, 14, 16'h0000);
    mdioWr(0, 13, 16'h401F);
    mdioRd(0, 14, v); chk("R6 no alias to entry 0", v, 16'h0000);
  endtask

  task automatic tOtherFn();
    logic [15:0] v;
    mdioWr(0, 13, 16'h001F);
    mdioWr(0, 14, 16'h0005);
    mdioWr(0, 13, 16'h801F);
    mdioRd(0, 14, v); chk("R7 fn 10 read", v, 16'h0000);
    mdioWr(0, 14, 16'h7777);
    mdioWr(0, 13, 16'hC01F);
    mdioWr(0, 14, 16'h6666);
    mdioRd(0, 14, v); chk("R7 fn 11 read", v, 16'h0000);
    mdioWr(0, 13, 16'h001F);
    mdioRd(0, 14, v); chk("R7 address untouched", v, 16'h0005);
    mdioWr(0, 13, 16'h401F);
    mdioRd(0, 14, v); chk("R7 ext reg untouched", v, 16'hBEEF);
  endtask

  task automatic tForeign();
    logic [15:0] v;
    mdioWr(1, 13, 16'h0000);
    mdioRd(0, 13, v); chk("R1 foreign phy write ignored", v, 16'h401F);
    mdioRd(1, 14, v); chk("R1 foreign phy read", v, 16'h0000);
    mdioWr(0, 2, 16'h0000);
    mdioRd(0, 2, v);  chk("R1 other reg read", v, 16'h0000);
    mdioRd(0, 14, v); chk("R1 other reg write ignored", v, 16'hBEEF);
  endtask

  task automatic tHold();
    logic [15:0] v;
    mdioRd(0, 13, v);
    @(negedge clk);
    regAddr = 5'd14; phyAddr = 5'd3;
    repeat (3) @(negedge clk);
    chk("R8 rdData held", rdData, 16'h401F);
  endtask

  task automatic tCollide();
    logic [15:0] v;
    @(negedge clk);
    phyAddr = 0; regAddr = 14; wrData = 16'h1111; wrStb = 1'b1; rdStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; rdStb = 1'b0;
    chk("R9 read sees old value", rdData, 16'hBEEF);
    mdioRd(0, 14, v); chk("R9 write committed", v, 16'h1111);
    @(negedge clk);
    phyAddr = 0; regAddr = 13; wrData = 16'h001F; wrStb = 1'b1; rdStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; rdStb = 1'b0;
    chk("R9 ctrl read sees old value", rdData, 16'h401F);
    mdioRd(0, 13, v); chk("R9 ctrl write committed", v, 16'h001F);
  endtask

  task automatic tMidReset();
    logic [15:0] v;
    mdioWr(0, 13, 16'h401F);
    doReset();
    chk("R10 rdData cleared", rdData, 16'h0000);
    mdioRd(0, 13, v); chk("R10 ctrl cleared", v, 16'h0000);
    mdioRd(0, 14, v); chk("R10 addr cleared", v, 16'h0000);
    mdioWr(0, 14, 16'h0005);
    mdioWr(0, 13, 16'h401F);
    mdioRd(0, 14, v); chk("R10 ext file cleared", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tReset();
    tCtrl();
    tAddrData();
    tOtherDev();
    tRange();
    tOtherFn();
    tForeign();
    tHold();
    tCollide();
    tMidReset();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule